// File: doc/BRIEF.md
# Thread Interrupt Presenter with Group Backlog

This block keeps the presentation context for a small set of hardware threads. For each thread it holds a current priority threshold, a notification status byte and a bitmap of pending direct priorities. It accepts interrupts aimed either at one named thread or at the whole group. An interrupt is presented only to a thread whose threshold is less favoured than the interrupt's priority. Lower priority numbers are more favoured.

A group interrupt goes to one eligible thread. When no thread in the group can take it, the block parks it in a shared backlog and reports the most favoured parked priority to every thread. A thread that later relaxes its threshold past a parked priority receives that interrupt at once. Software sees each thread through a 32-bit status word. It takes an interrupt with an acknowledge command, which returns the status and the priority that was taken, and moves the threshold to that priority.

The block has one command port with four operations, a status read port selected by thread index, and one interrupt line per thread. Event queues, source state bits and memory tables are outside this block.

Top module: `tip_presenter`

## Requirements
- R1: After a synchronous active-low reset every thread reads status 0x00FF00FF (status 0x00, threshold 0xFF, nothing pending, nothing backlogged) and every interrupt line is low.
- R2: A direct trigger (cmd_op 2'b00) with priority p below 8 sets bit (0x80 >> p) of the addressed thread's pending byte, whether or not it is presented.
- R3: A direct trigger is presented (status 0x40, interrupt line high) when p is numerically lower than the thread's threshold and the thread shows no status. Otherwise it is only held in the pending byte.
- R4: An acknowledge (cmd_op 2'b11) of a thread showing 0x40 returns {0x40, p}, where p is its most favoured pending priority. It sets the threshold to p, clears that pending bit and drops the status to 0x00.
- R5: A group trigger (cmd_op 2'b01) with priority p is presented with status 0x82 on exactly one thread: the lowest-index thread whose status is 0x00 and whose threshold is numerically greater than p. A threshold equal to p is not eligible.
- R6: A group trigger with no eligible thread changes no status. It records p in the backlog, and the lowest byte of every thread's status word then shows it.
- R7: The backlog byte shows the most favoured parked priority, and 0xFF when the backlog is empty.
- R8: A threshold write (cmd_op 2'b10) to a thread without group status, with a value numerically greater than the backlog byte, presents that parked priority with status 0x82 and removes one entry at that priority from the backlog.
- R9: An acknowledge of a thread showing 0x82 returns {0x82, p} and sets the threshold to p. An acknowledge of a thread showing 0x00 returns {0x00, threshold} and changes nothing.
- R10: A threshold write presents a held direct priority (status 0x40) when it is lower than the new threshold and not less favoured than the backlog byte. If nothing qualifies, the status drops to 0x00.
- R11: A trigger, direct or group, whose priority is 8 or more is ignored: no status, pending bit or backlog entry changes.
- R12: The status word for rd_thread is {status[31:24], threshold[23:16], pending[15:8], backlog[7:0]}, and irq[i] is high exactly when thread i shows a non-zero status.
- R13: ack_valid pulses, with ack_word valid, in the cycle after an acknowledge command, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 00 direct trigger, 01 group trigger, 10 threshold write, 11 acknowledge |
| cmd_thread | input | $clog2(NTHR) | Addressed thread (ignored for group trigger) |
| cmd_data | input | 8 | Priority for triggers, new threshold for writes |
| rd_thread | input | $clog2(NTHR) | Thread whose status word is shown |
| status_word | output | 32 | Status, threshold, pending byte, backlog byte |
| irq | output | NTHR | Per-thread interrupt line |
| ack_valid | output | 1 | Acknowledge response strobe |
| ack_word | output | 16 | {status, new threshold} from the acknowledge |

## Verification
A wrong status or pending bit shows on irq and in the status word in the cycle after the command that caused it. The acknowledge response reveals the wrong priority one cycle after the acknowledge. A backlog counter that is off shows later: the backlog byte stays stuck or clears too early, and a threshold write that should pull a parked interrupt leaves the thread silent. The bench drains the backlog one entry at a time and reads the backlog byte after each step, so a counting error appears within one command of where it happens.

// File: rtl/tip_pkg.sv
// Shared constants and command encoding for the thread interrupt presenter.
package tip_pkg;
    localparam logic [7:0] NSR_IDLE   = 8'h00;
    localparam logic [7:0] NSR_DIRECT = 8'h40;
    localparam logic [7:0] NSR_GROUP  = 8'h82;
    localparam logic [7:0] PRIO_NONE  = 8'hFF;

    typedef enum logic [1:0] {
        OP_TRIG_THR = 2'b00,
        OP_TRIG_GRP = 2'b01,
        OP_SET_CPPR = 2'b10,
        OP_ACK      = 2'b11
    } tip_op_e;
endpackage

// File: rtl/tip_thread_ctx.sv
// Per-thread presentation context: threshold, status byte, pending bitmap and
// the priority of a presented group interrupt.
// Assumes at most one command per cycle and that grp_win fires only on a
// valid group trigger.
module tip_thread_ctx
    import tip_pkg::*;
#(
    parameter int NPRIO = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  tip_op_e     op,
    input  logic [7:0]  data,
    input  logic        grp_win,
    input  logic [7:0]  bl_min,
    output logic [7:0]  cppr,
    output logic [7:0]  nsr,
    output logic [7:0]  ipb_byte,
    output logic        bl_pull,
    output logic [15:0] ack_word
);
    localparam int PW = $clog2(NPRIO);
    localparam logic [7:0] NPRIO_B = 8'(NPRIO);

    logic [NPRIO-1:0] pend;
    logic [7:0]       gprio;
    logic [7:0]       ipb_min;
    logic             prio_ok;
    logic             take_direct;
    logic             take_bl;

    // Most favoured pending direct priority, 0xFF when none.
    always_comb begin
        ipb_min = PRIO_NONE;
        for (int p = NPRIO - 1; p >= 0; p--) begin
            if (pend[p]) ipb_min = 8'(p);
        end
    end

    // Pending bitmap laid out with priority 0 at the top bit.
    always_comb begin
        ipb_byte = '0;
        for (int p = 0; p < NPRIO; p++) begin
            ipb_byte[7-p] = pend[p];
        end
    end

    // Decide which source a threshold write would present.
    always_comb begin
        prio_ok     = data < NPRIO_B;
        take_direct = (ipb_min < data) && (ipb_min <= bl_min);
        take_bl     = !take_direct && (bl_min < data);
        bl_pull     = sel && (op == OP_SET_CPPR) && (nsr != NSR_GROUP) && take_bl;
    end

    // Response word an acknowledge would return this cycle.
    always_comb begin
        unique case (nsr)
            NSR_DIRECT: ack_word = {nsr, ipb_min};
            NSR_GROUP:  ack_word = {nsr, gprio};
            default:    ack_word = {nsr, cppr};
        endcase
    end

    // Context state update for the command addressed to this thread.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cppr  <= PRIO_NONE;
            nsr   <= NSR_IDLE;
            pend  <= '0;
            gprio <= PRIO_NONE;
        end else if (grp_win) begin
            nsr   <= NSR_GROUP;
            gprio <= data;
        end else if (sel) begin
            unique case (op)
                OP_TRIG_THR: begin
                    if (prio_ok) begin
                        pend[data[PW-1:0]] <= 1'b1;
                        if (nsr == NSR_IDLE && data < cppr) nsr <= NSR_DIRECT;
                    end
                end
                OP_SET_CPPR: begin
                    cppr <= data;
                    if (nsr != NSR_GROUP) begin
                        if (take_direct) begin
                            nsr <= NSR_DIRECT;
                        end else if (take_bl) begin
                            nsr   <= NSR_GROUP;
                            gprio <= bl_min;
                        end else begin
                            nsr <= NSR_IDLE;
                        end
                    end
                end
                OP_ACK: begin
                    if (nsr == NSR_DIRECT) begin
                        cppr                  <= ipb_min;
                        pend[ipb_min[PW-1:0]] <= 1'b0;
                        nsr                   <= NSR_IDLE;
                    end else if (nsr == NSR_GROUP) begin
                        cppr  <= gprio;
                        gprio <= PRIO_NONE;
                        nsr   <= NSR_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tip_backlog.sv
// Shared backlog of group interrupts that found no eligible thread: one
// saturating counter per priority and the most favoured non-empty priority.
// Assumes push and pull never occur in the same cycle.
module tip_backlog
    import tip_pkg::*;
#(
    parameter int NPRIO = 8,
    parameter int CNT_W = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push,
    input  logic [7:0] push_prio,
    input  logic       pull,
    output logic [7:0] min_prio
);
    localparam int PW = $clog2(NPRIO);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt [NPRIO];

    // Most favoured priority with a parked entry, 0xFF when empty.
    always_comb begin
        min_prio = PRIO_NONE;
        for (int p = NPRIO - 1; p >= 0; p--) begin
            if (cnt[p] != '0) min_prio = 8'(p);
        end
    end

    // Counter updates: add on push, remove the most favoured entry on pull.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPRIO; p++) cnt[p] <= '0;
        end else if (push) begin
            if (cnt[push_prio[PW-1:0]] != CNT_MAX)
                cnt[push_prio[PW-1:0]] <= cnt[push_prio[PW-1:0]] + 1'b1;
        end else if (pull && min_prio != PRIO_NONE) begin
            cnt[min_prio[PW-1:0]] <= cnt[min_prio[PW-1:0]] - 1'b1;
        end
    end
endmodule

// File: rtl/tip_group_pick.sv
// Fixed-order selector: grants the lowest-index eligible thread.
// Assumes nothing about the eligibility vector; an empty vector grants none.
module tip_group_pick #(
    parameter int NTHR = 4
) (
    input  logic [NTHR-1:0] elig,
    output logic [NTHR-1:0] win,
    output logic            any
);
    // Isolate the lowest set bit.
    always_comb begin
        win = elig & (~elig + 1'b1);
        any = |elig;
    end
endmodule

// File: rtl/tip_presenter.sv
// Top of the thread interrupt presenter: decodes commands, routes group
// triggers to a chosen thread or to the backlog, and exposes status words.
// Assumes NTHR is a power of two of at least 2 and NPRIO is at most 8.
module tip_presenter
    import tip_pkg::*;
#(
    parameter int NTHR     = 4,
    parameter int NPRIO    = 8,
    parameter int BL_CNT_W = 4,
    localparam int TW      = $clog2(NTHR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [TW-1:0]   cmd_thread,
    input  logic [7:0]      cmd_data,
    input  logic [TW-1:0]   rd_thread,
    output logic [31:0]     status_word,
    output logic [NTHR-1:0] irq,
    output logic            ack_valid,
    output logic [15:0]     ack_word
);
    localparam logic [7:0] NPRIO_B = 8'(NPRIO);

    tip_op_e         op;
    logic            grp_trig;
    logic [NTHR-1:0] elig;
    logic [NTHR-1:0] win;
    logic            any_win;
    logic [NTHR-1:0] pull_v;
    logic [7:0]      lsmfb;
    logic [7:0]      cppr_a [NTHR];
    logic [7:0]      nsr_a  [NTHR];
    logic [7:0]      ipb_a  [NTHR];
    logic [15:0]     ackw_a [NTHR];

    // Command decode shared by all threads.
    always_comb begin
        op       = tip_op_e'(cmd_op);
        grp_trig = cmd_valid && (op == OP_TRIG_GRP) && (cmd_data < NPRIO_B);
    end

    for (genvar i = 0; i < NTHR; i++) begin : g_thr
        // Eligibility of this thread for the current group trigger.
        always_comb elig[i] = grp_trig && (nsr_a[i] == NSR_IDLE) && (cmd_data < cppr_a[i]);

        tip_thread_ctx #(.NPRIO(NPRIO)) u_ctx (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (cmd_valid && (cmd_thread == TW'(i))),
            .op       (op),
            .data     (cmd_data),
            .grp_win  (win[i]),
            .bl_min   (lsmfb),
            .cppr     (cppr_a[i]),
            .nsr      (nsr_a[i]),
            .ipb_byte (ipb_a[i]),
            .bl_pull  (pull_v[i]),
            .ack_word (ackw_a[i])
        );

        // Interrupt line follows the status byte.
        always_comb irq[i] = nsr_a[i] != NSR_IDLE;
    end

    tip_group_pick #(.NTHR(NTHR)) u_pick (
        .elig (elig),
        .win  (win),
        .any  (any_win)
    );

    tip_backlog #(.NPRIO(NPRIO), .CNT_W(BL_CNT_W)) u_bl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (grp_trig && !any_win),
        .push_prio (cmd_data),
        .pull      (|pull_v),
        .min_prio  (lsmfb)
    );

    // Status word for the selected thread.
    always_comb status_word = {nsr_a[rd_thread], cppr_a[rd_thread], ipb_a[rd_thread], lsmfb};

    // Register the acknowledge response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid <= 1'b0;
            ack_word  <= '0;
        end else begin
            ack_valid <= cmd_valid && (op == OP_ACK);
            if (cmd_valid && op == OP_ACK) ack_word <= ackw_a[cmd_thread];
        end
    end
endmodule

// File: rtl/tip_presenter_chk.sv
// Property checker for tip_presenter, attached through bind.
// Assumes it sees the top's ports and the internal backlog byte.
module tip_presenter_chk #(
    parameter int NTHR  = 4,
    parameter int NPRIO = 8,
    localparam int TW   = $clog2(NTHR)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic [1:0]      cmd_op,
    input logic [TW-1:0]   cmd_thread,
    input logic [7:0]      cmd_data,
    input logic [NTHR-1:0] irq,
    input logic            ack_valid,
    input logic [7:0]      lsmfb
);
    localparam logic [7:0] NPRIO_B = 8'(NPRIO);

    p_ack_latency_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11) |=> ack_valid);

    p_no_stray_ack_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_valid && cmd_op == 2'b11) |=> !ack_valid);

    p_single_winner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b01) |=> $countones(irq & ~$past(irq)) <= 1);

    p_ack_drops_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'b11) |=> !irq[$past(cmd_thread)]);

    p_bad_prio_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_op[1] && cmd_data >= NPRIO_B) |=> ($stable(irq) && $stable(lsmfb)));

    p_backlog_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (lsmfb == 8'hFF) || (lsmfb < NPRIO_B));
endmodule

bind tip_presenter tip_presenter_chk #(.NTHR(NTHR), .NPRIO(NPRIO)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_thread (cmd_thread),
    .cmd_data   (cmd_data),
    .irq        (irq),
    .ack_valid  (ack_valid),
    .lsmfb      (lsmfb)
);

// File: tb/tb_tip_presenter.sv
module tb_tip_presenter;
    localparam int NTHR = 4;
    localparam int TW   = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [1:0]      cmd_op = 2'b00;
    logic [TW-1:0]   cmd_thread = '0;
    logic [7:0]      cmd_data = '0;
    logic [TW-1:0]   rd_thread = '0;
    logic [31:0]     status_word;
    logic [NTHR-1:0] irq;
    logic            ack_valid;
    logic [15:0]     ack_word;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [15:0] exp_q [$];
    string       tag_q [$];

    always #2 clk = ~clk;

    tip_presenter #(.NTHR(NTHR)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_thread(cmd_thread), .cmd_data(cmd_data), .rd_thread(rd_thread),
        .status_word(status_word), .irq(irq), .ack_valid(ack_valid), .ack_word(ack_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] op, input int thr, input logic [7:0] d);
        @(negedge clk);
        cmd_valid  = 1'b1;
        cmd_op     = op;
        cmd_thread = TW'(thr);
        cmd_data   = d;
        @(posedge clk);
        #1 cmd_valid = 1'b0;
    endtask

    // Driver for acknowledges: pushes the expected response into the scoreboard.
    task automatic ack(input int thr, input logic [15:0] exp, input string req);
        exp_q.push_back(exp);
        tag_q.push_back(req);
        issue(2'b11, thr, 8'h00);
    endtask

    task automatic stat(input int thr, input logic [31:0] exp, input string req);
        rd_thread = TW'(thr);
        #1 chk(req, status_word, exp);
    endtask

    // Monitor: compares each acknowledge response against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && ack_valid) begin
            if (exp_q.size() == 0) begin
                chk("R13 unexpected ack", {16'h0, ack_word}, 32'hFFFF_FFFF);
            end else begin
                automatic logic [15:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                chk(t, {16'h0, ack_word}, {16'h0, e});
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        for (int t = 0; t < NTHR; t++) stat(t, 32'h00FF00FF, "R1 reset status");
        chk("R1 irq after reset", {28'h0, irq}, 32'h0);

        // R2 R3 direct trigger presented
        issue(2'b00, 1, 8'd5);
        stat(1, 32'h40FF04FF, "R2 R3 direct present");
        chk("R12 irq line", {28'h0, irq}, 32'h2);
        // R4 acknowledge of direct
        ack(1, 16'h4005, "R4 direct ack word");
        stat(1, 32'h000500FF, "R4 state after ack");
        issue(2'b10, 1, 8'hFF);
        stat(1, 32'h00FF00FF, "R10 threshold reopen");

        // R11 out-of-range direct priority
        issue(2'b00, 0, 8'd9);
        stat(0, 32'h00FF00FF, "R11 direct prio 9 ignored");
        chk("R11 irq unchanged", {28'h0, irq}, 32'h0);

        // R5 group selection order
        issue(2'b01, 0, 8'd6);
        stat(0, 32'h82FF00FF, "R5 first group to t0");
        stat(1, 32'h00FF00FF, "R5 t1 untouched");
        issue(2'b01, 0, 8'd4);
        stat(1, 32'h82FF00FF, "R5 second group to t1");
        chk("R5 irq lines", {28'h0, irq}, 32'h3);
        ack(0, 16'h8206, "R9 group ack t0");
        ack(1, 16'h8204, "R9 group ack t1");
        stat(0, 32'h000600FF, "R9 t0 threshold");

        // R6 R7 backlog fill
        for (int t = 0; t < NTHR; t++) issue(2'b10, t, 8'd2);
        stat(2, 32'h000200FF, "R10 threshold write no source");
        issue(2'b01, 0, 8'd3);
        stat(0, 32'h00020003, "R6 backlog recorded");
        chk("R6 no irq", {28'h0, irq}, 32'h0);
        issue(2'b01, 0, 8'd5);
        stat(1, 32'h00020003, "R7 most favoured kept");

        // R8 drain backlog
        issue(2'b10, 3, 8'd4);
        stat(3, 32'h82040005, "R8 pull prio 3");
        ack(3, 16'h8203, "R9 backlog ack");
        stat(3, 32'h00030005, "R9 state after backlog ack");
        issue(2'b10, 2, 8'hFF);
        stat(2, 32'h82FF00FF, "R8 R7 pull prio 5, backlog empty");
        ack(2, 16'h8205, "R9 second backlog ack");
        issue(2'b10, 2, 8'hFF);
        stat(2, 32'h00FF00FF, "R7 cleared context");

        // R3 R10 blocked direct then re-presented
        issue(2'b00, 0, 8'd4);
        stat(0, 32'h000208FF, "R3 direct held");
        chk("R3 no irq while held", {28'h0, irq}, 32'h0);
        issue(2'b10, 0, 8'd6);
        stat(0, 32'h400608FF, "R10 direct re-presented");
        ack(0, 16'h4004, "R4 held direct ack");
        ack(0, 16'h0004, "R9 idle ack");
        stat(0, 32'h000400FF, "R9 idle ack no change");

        // R11 out-of-range group priority
        issue(2'b01, 0, 8'd9);
        stat(1, 32'h000200FF, "R11 group prio 9 ignored");
        chk("R11 group irq", {28'h0, irq}, 32'h0);

        // R5 equal threshold not eligible: t0 cppr 4, t3 cppr 3
        issue(2'b01, 0, 8'd3);
        stat(0, 32'h820400FF, "R5 lowest eligible wins");
        stat(3, 32'h000300FF, "R5 equal threshold skipped");
        ack(0, 16'h8203, "R9 boundary ack");

        @(negedge clk);
        @(negedge clk);
        chk("R13 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule